// File: doc/BRIEF.md
# BCD-capable add/subtract unit

This block is the arithmetic core for accumulator add-with-carry and subtract-with-borrow. One operation is applied per accepted input. It works in plain binary or in packed decimal, where each 4-bit nibble holds one decimal digit. The operand width is 8 or 16 bits and is chosen per operation. In the narrow width only the low byte takes part. The upper accumulator byte comes back as it went in.

The arithmetic itself is purely combinational. A single output register stage sits at the boundary so that results and flags are available one clock after an input is presented with `in_valid` high. When `in_valid` is low the register holds its contents. The four operation kinds are binary add, binary subtract, decimal add and decimal subtract. They are selected from `{dec_in, sub_in}` with a `unique case`. Decimal results are built by a digit chain that corrects one nibble at a time from the lowest upward.

Top module: `bcd_alu`

## Requirements
- R1: When `in_valid` is high at a rising edge, all outputs take the new operation's values and `out_valid` is high after that edge. When `in_valid` is low, `res_out` and all flags hold their values and `out_valid` is low.
- R2: Decimal add (`dec_in`=1, `sub_in`=0) works one digit at a time, starting from the lowest digit. The digit sum is the accumulator nibble plus the operand nibble plus the incoming link; the link into the lowest digit is `carry_in`. If that sum is above 9, the digit becomes the low four bits of (sum − 10) and the link into the next digit is 1. Otherwise the digit is the low four bits of the sum and the link is 0.
- R3: In decimal add, `carry_out` is the link leaving the top active digit: digit 3 in wide mode, digit 1 in narrow mode.
- R4: Decimal subtract (`dec_in`=1, `sub_in`=1) forms a signed value for each digit: the accumulator nibble minus the operand nibble minus the incoming lend. The lowest digit also subtracts (1 − `carry_in`). If the value is negative or above 9, the digit becomes the low four bits of (value + 10) and the next digit receives a lend of 1. Otherwise the digit is the low four bits of the value.
- R5: In decimal subtract, `carry_out` is 0 if the top active digit was corrected and 1 otherwise.
- R6: Binary add gives A + B + `carry_in` over the active width. `carry_out` is 1 exactly when that sum exceeds 0xFF (narrow) or 0xFFFF (wide).
- R7: Binary subtract gives A − B − (1 − `carry_in`) over the active width. `carry_out` is 1 exactly when that difference is not negative.
- R8: `ovf_out` is the top active bit of ~(A^B)&(A^R) for add, and of (A^B)&(A^R) for subtract. R is the final result after any decimal correction.
- R9: `neg_out` is the top active result bit: bit 15 when wide, bit 7 when narrow. `zero_out` is 1 exactly when the active bits of the result are all zero.
- R10: With `wide_in`=0, `res_out[15:8]` equals `acc_in[15:8]`, and `opnd_in[15:8]` has no effect on any output.
- R11: While `rst_n` is low, `out_valid`, `res_out` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept the operation on this edge |
| acc_in | input | 16 | Accumulator value A |
| opnd_in | input | 16 | Operand value B |
| carry_in | input | 1 | Carry flag in (1 = no borrow for subtract) |
| dec_in | input | 1 | 1 = packed-decimal arithmetic |
| wide_in | input | 1 | 1 = 16-bit, 0 = 8-bit |
| sub_in | input | 1 | 1 = subtract, 0 = add |
| out_valid | output | 1 | Registered result is from the previous edge |
| res_out | output | 16 | Result |
| carry_out | output | 1 | New carry flag |
| neg_out | output | 1 | New negative flag |
| ovf_out | output | 1 | New overflow flag |
| zero_out | output | 1 | New zero flag |

## Verification
The narrow width is swept over every accumulator byte, against operands chosen to hit digit boundaries (09, 10, 99, 9A, FF). This covers both carry-in values and all four operation kinds, plus several thousand wide vectors, half of them made of legal decimal digits. A decimal subtract that tested only the 4-bit wrapped digit would miss the correction when a digit difference is −10 or below, and would leave 6 instead of 0 in digits such as 0 − 9 − 1. Overflow taken before decimal correction, or a narrow-mode carry or zero taken from bit 15, would show up as flag mismatches across the sweep. A design that touched the upper byte in narrow mode would fail the pass-through comparisons, because the upper operand byte differs from the accumulator's in every narrow vector.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        KIND_BIN_ADD = 2'd0,
        KIND_BIN_SUB = 2'd1,
        KIND_DEC_ADD = 2'd2,
        KIND_DEC_SUB = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic carry;
        logic neg;
        logic ovf;
        logic zero;
    } flag_set_t;

endpackage

// File: rtl/bcd_dec_chain.sv
module bcd_dec_chain #(
    parameter int DIGITS = 4,
    localparam int W = DIGITS * bcd_alu_pkg::NIB_W,
    localparam int HALF_DIG = DIGITS / 2
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         carry_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         carry_half_o,
    output logic         carry_full_o
);
    logic [DIGITS-1:0] link;
    logic [DIGITS-1:0] dig_carry;

    assign link[0] = sub_i ? 1'b0 : carry_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        logic [3:0] an;
        logic [3:0] bn;
        logic       first;
        logic [4:0] add_s;
        logic [4:0] add_m;
        logic       fix_add;
        logic [5:0] sub_v;
        logic [5:0] sub_p;
        logic       fix_sub;

        assign an = a_i[g*4 +: 4];
        assign bn = b_i[g*4 +: 4];

        if (g == 0) begin : g_lo
            assign first = ~carry_i;
        end else begin : g_up
            assign first = 1'b0;
        end

        // add path: unsigned digit sum, corrected above nine
        assign add_s   = {1'b0, an} + {1'b0, bn} + {4'b0, link[g]};
        assign fix_add = add_s > 5'd9;
        assign add_m   = add_s - 5'd10;

        // subtract path: signed digit value, corrected when negative or above nine
        assign sub_v   = {2'b0, an} - {2'b0, bn} - {5'b0, first} - {5'b0, link[g]};
        assign fix_sub = sub_v[5] | (sub_v[4:0] > 5'd9);
        assign sub_p   = sub_v + 6'd10;

        assign sum_o[g*4 +: 4] = sub_i ? (fix_sub ? sub_p[3:0] : sub_v[3:0])
                                       : (fix_add ? add_m[3:0] : add_s[3:0]);
        assign dig_carry[g]    = sub_i ? ~fix_sub : fix_add;

        if (g < DIGITS - 1) begin : g_next
            assign link[g+1] = sub_i ? fix_sub : fix_add;
        end
    end

    assign carry_half_o = dig_carry[HALF_DIG-1];
    assign carry_full_o = dig_carry[DIGITS-1];

endmodule

// File: rtl/bcd_bin_path.sv
module bcd_bin_path #(
    parameter int W = 16,
    localparam int H = W / 2
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         carry_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         carry_half_o,
    output logic         carry_full_o
);
    logic [W-1:0] b_eff;
    logic [H:0]   lo;
    logic [H:0]   hi;

    // subtract as A + ~B + C, so carry out means no borrow
    assign b_eff = sub_i ? ~b_i : b_i;
    assign lo    = {1'b0, a_i[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, carry_i};
    assign hi    = {1'b0, a_i[W-1:H]} + {1'b0, b_eff[W-1:H]} + {{H{1'b0}}, lo[H]};

    assign sum_o        = {hi[H-1:0], lo[H-1:0]};
    assign carry_half_o = lo[H];
    assign carry_full_o = hi[H];

endmodule

// File: rtl/bcd_alu_flags.sv
module bcd_alu_flags #(
    parameter int W = 16,
    localparam int H = W / 2
) (
    input  logic [W-1:0] r_i,
    input  logic [1:0]   a_msb_i,  // {bit W-1, bit H-1}
    input  logic [1:0]   b_msb_i,
    input  logic         wide_i,
    input  logic         sub_i,
    output logic         neg_o,
    output logic         ovf_o,
    output logic         zero_o
);
    logic [1:0] r_msb;
    logic [1:0] ovf_pair;

    assign r_msb = {r_i[W-1], r_i[H-1]};

    for (genvar k = 0; k < 2; k++) begin : g_ovf
        assign ovf_pair[k] = sub_i ? ((a_msb_i[k] ^ b_msb_i[k]) & (a_msb_i[k] ^ r_msb[k]))
                                   : (~(a_msb_i[k] ^ b_msb_i[k]) & (a_msb_i[k] ^ r_msb[k]));
    end

    assign neg_o  = wide_i ? r_msb[1]    : r_msb[0];
    assign ovf_o  = wide_i ? ovf_pair[1] : ovf_pair[0];
    assign zero_o = wide_i ? (r_i == '0) : (r_i[H-1:0] == '0);

endmodule

// File: rtl/bcd_alu.sv
module bcd_alu #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic              carry_in,
    input  logic              dec_in,
    input  logic              wide_in,
    input  logic              sub_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] res_out,
    output logic              carry_out,
    output logic              neg_out,
    output logic              ovf_out,
    output logic              zero_out
);
    import bcd_alu_pkg::*;

    localparam int HALF_W = DATA_W / 2;
    localparam int DIGITS = DATA_W / NIB_W;

    op_kind_e          kind;
    logic [DATA_W-1:0] dec_sum;
    logic              dec_c_half;
    logic              dec_c_full;
    logic [DATA_W-1:0] bin_sum;
    logic              bin_c_half;
    logic              bin_c_full;
    logic [DATA_W-1:0] raw;
    logic              raw_carry;
    logic [DATA_W-1:0] merged;
    flag_set_t         next_flags;
    flag_set_t         flags_q;
    logic [DATA_W-1:0] res_q;
    logic              valid_q;

    assign kind = op_kind_e'({dec_in, sub_in});

    bcd_dec_chain #(.DIGITS(DIGITS)) u_dec (
        .a_i          (acc_in),
        .b_i          (opnd_in),
        .carry_i      (carry_in),
        .sub_i        (sub_in),
        .sum_o        (dec_sum),
        .carry_half_o (dec_c_half),
        .carry_full_o (dec_c_full)
    );

    bcd_bin_path #(.W(DATA_W)) u_bin (
        .a_i          (acc_in),
        .b_i          (opnd_in),
        .carry_i      (carry_in),
        .sub_i        (sub_in),
        .sum_o        (bin_sum),
        .carry_half_o (bin_c_half),
        .carry_full_o (bin_c_full)
    );

    always_comb begin
        unique case (kind)
            KIND_BIN_ADD, KIND_BIN_SUB: begin
                raw       = bin_sum;
                raw_carry = wide_in ? bin_c_full : bin_c_half;
            end
            KIND_DEC_ADD, KIND_DEC_SUB: begin
                raw       = dec_sum;
                raw_carry = wide_in ? dec_c_full : dec_c_half;
            end
            default: begin
                raw       = '0;
                raw_carry = 1'b0;
            end
        endcase
    end

    assign merged = wide_in ? raw : {acc_in[DATA_W-1:HALF_W], raw[HALF_W-1:0]};

    bcd_alu_flags #(.W(DATA_W)) u_flags (
        .r_i     (merged),
        .a_msb_i ({acc_in[DATA_W-1], acc_in[HALF_W-1]}),
        .b_msb_i ({opnd_in[DATA_W-1], opnd_in[HALF_W-1]}),
        .wide_i  (wide_in),
        .sub_i   (sub_in),
        .neg_o   (next_flags.neg),
        .ovf_o   (next_flags.ovf),
        .zero_o  (next_flags.zero)
    );

    assign next_flags.carry = raw_carry;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            res_q   <= '0;
            flags_q <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                res_q   <= merged;
                flags_q <= next_flags;
            end
        end
    end

    always_comb begin
        out_valid = valid_q;
        res_out   = res_q;
        carry_out = flags_q.carry;
        neg_out   = flags_q.neg;
        ovf_out   = flags_q.ovf;
        zero_out  = flags_q.zero;
    end

endmodule

// File: rtl/bcd_alu_chk.sv
module bcd_alu_chk #(
    parameter int DATA_W = 16,
    localparam int HALF_W = DATA_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] opnd_in,
    input logic              carry_in,
    input logic              dec_in,
    input logic              wide_in,
    input logic              sub_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] res_out,
    input logic              carry_out,
    input logic              neg_out,
    input logic              ovf_out,
    input logic              zero_out
);
    function automatic logic all_digits(input logic [DATA_W-1:0] x);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DATA_W / 4; i++) begin
            if (x[i*4 +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(res_out) && $stable(carry_out)
                     && $stable(neg_out) && $stable(ovf_out) && $stable(zero_out));

    assert_dec_add_digits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && dec_in && !sub_in && wide_in && all_digits(acc_in) && all_digits(opnd_in)
        |=> all_digits(res_out));

    assert_dec_sub_borrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && dec_in && sub_in && wide_in && all_digits(acc_in) && all_digits(opnd_in)
        |=> carry_out == ({1'b0, $past(acc_in)} >= ({1'b0, $past(opnd_in)} + {{DATA_W{1'b0}}, ~$past(carry_in)})));

    assert_bin_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !dec_in && !sub_in && wide_in
        |=> {carry_out, res_out} == ({1'b0, $past(acc_in)} + {1'b0, $past(opnd_in)}
                                     + {{DATA_W{1'b0}}, $past(carry_in)}));

    assert_bin_sub_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !dec_in && sub_in && wide_in
        |=> carry_out == ({1'b0, $past(acc_in)} >= ({1'b0, $past(opnd_in)} + {{DATA_W{1'b0}}, ~$past(carry_in)})));

    assert_neg_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> neg_out == ($past(wide_in) ? res_out[DATA_W-1] : res_out[HALF_W-1]));

    assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> zero_out == ($past(wide_in) ? (res_out == '0) : (res_out[HALF_W-1:0] == '0)));

    assert_narrow_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !wide_in |=> res_out[DATA_W-1:HALF_W] == $past(acc_in[DATA_W-1:HALF_W]));

endmodule

bind bcd_alu bcd_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .acc_in    (acc_in),
    .opnd_in   (opnd_in),
    .carry_in  (carry_in),
    .dec_in    (dec_in),
    .wide_in   (wide_in),
    .sub_in    (sub_in),
    .out_valid (out_valid),
    .res_out   (res_out),
    .carry_out (carry_out),
    .neg_out   (neg_out),
    .ovf_out   (ovf_out),
    .zero_out  (zero_out)
);

// File: tb/bcd_alu_tb.sv
module bcd_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] acc_in = '0;
    logic [15:0] opnd_in = '0;
    logic        carry_in = 1'b0;
    logic        dec_in = 1'b0;
    logic        wide_in = 1'b0;
    logic        sub_in = 1'b0;
    logic        out_valid;
    logic [15:0] res_out;
    logic        carry_out;
    logic        neg_out;
    logic        ovf_out;
    logic        zero_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    bcd_alu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .acc_in(acc_in), .opnd_in(opnd_in), .carry_in(carry_in),
        .dec_in(dec_in), .wide_in(wide_in), .sub_in(sub_in),
        .out_valid(out_valid), .res_out(res_out), .carry_out(carry_out),
        .neg_out(neg_out), .ovf_out(ovf_out), .zero_out(zero_out)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // arithmetic reference built from the requirement text
    task automatic model(input int a, input int b, input int c, input bit dec, input bit sub,
                         input bit wide, output logic [15:0] r_o, output logic c_o,
                         output logic n_o, output logic v_o, output logic z_o);
        int nd, w, mask, r, link, v, top;
        nd = wide ? 4 : 2;
        w = wide ? 16 : 8;
        mask = (1 << w) - 1;
        a = a & mask;
        b = b & mask;
        r = 0;
        if (dec && !sub) begin
            link = c;
            for (int i = 0; i < nd; i++) begin
                v = ((a >> (4*i)) & 15) + ((b >> (4*i)) & 15) + link;
                if (v > 9) begin v = (v - 10) & 15; link = 1; end
                else begin link = 0; end
                r = r | (v << (4*i));
            end
            c_o = link[0];
        end else if (dec && sub) begin
            link = 0;
            for (int i = 0; i < nd; i++) begin
                v = ((a >> (4*i)) & 15) - ((b >> (4*i)) & 15) - link - ((i == 0) ? (1 - c) : 0);
                if (v < 0 || v > 9) begin v = (v + 10) & 15; link = 1; end
                else begin link = 0; end
                r = r | ((v & 15) << (4*i));
            end
            c_o = (link == 0);
        end else if (!sub) begin
            v = a + b + c;
            c_o = (v > mask);
            r = v & mask;
        end else begin
            v = a - b - (1 - c);
            c_o = (v >= 0);
            r = v & mask;
        end
        top = w - 1;
        n_o = r[top];
        if (sub) v_o = ((a ^ b) & (a ^ r)) >> top;
        else     v_o = ((~(a ^ b)) & (a ^ r)) >> top;
        z_o = (r == 0);
        r_o = 16'(r);
    endtask

    task automatic apply(input logic [15:0] a, input logic [15:0] b, input bit c,
                         input bit dec, input bit sub, input bit wide);
        logic [15:0] er;
        logic ec, en, ev, ez;
        string mtag, ctag;
        @(negedge clk);
        acc_in = a; opnd_in = b; carry_in = c;
        dec_in = dec; sub_in = sub; wide_in = wide; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        model(int'(a), int'(b), int'(c), dec, sub, wide, er, ec, en, ev, ez);
        if (!wide) er[15:8] = a[15:8];
        if (dec && !sub)      begin mtag = "R2 dec add result";  ctag = "R3 dec add carry"; end
        else if (dec && sub)  begin mtag = "R4 dec sub result";  ctag = "R5 dec sub carry"; end
        else if (!sub)        begin mtag = "R6 bin add result";  ctag = "R6 bin add carry"; end
        else                  begin mtag = "R7 bin sub result";  ctag = "R7 bin sub carry"; end
        if (wide) chk(mtag, res_out, er);
        else begin
            chk(mtag, {8'h00, res_out[7:0]}, {8'h00, er[7:0]});
            chk("R10 narrow upper byte", {8'h00, res_out[15:8]}, {8'h00, er[15:8]});
        end
        chk(ctag, {15'b0, carry_out}, {15'b0, ec});
        chk("R8 overflow", {15'b0, ovf_out}, {15'b0, ev});
        chk("R9 negative", {15'b0, neg_out}, {15'b0, en});
        chk("R9 zero", {15'b0, zero_out}, {15'b0, ez});
        chk("R1 out_valid after accept", {15'b0, out_valid}, 16'h0001);
    endtask

    function automatic logic [7:0] opnd_pick(input int k);
        case (k)
            0: return 8'h00;  1: return 8'h09;  2: return 8'h10;  3: return 8'h11;
            4: return 8'h45;  5: return 8'h50;  6: return 8'h59;  7: return 8'h90;
            8: return 8'h99;  9: return 8'h9A;  10: return 8'hAF; 11: return 8'hFF;
            12: return 8'h01; 13: return 8'h80; 14: return 8'h7F; default: return 8'h66;
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] keep_r;
        logic keep_c;
        // R11: reset state, with inputs asking for an operation
        acc_in = 16'h1234; opnd_in = 16'h4321; in_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 reset out_valid", {15'b0, out_valid}, 16'h0000);
        chk("R11 reset result", res_out, 16'h0000);
        chk("R11 reset flags", {12'b0, carry_out, neg_out, ovf_out, zero_out}, 16'h0000);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // directed decimal corners
        apply(16'h0000, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b1); // R4: 0000-0001 -> 9999, borrow
        chk("R4 wraps to 9999", res_out, 16'h9999);
        chk("R5 borrow on wrap", {15'b0, carry_out}, 16'h0000);
        apply(16'h0000, 16'h0009, 1'b0, 1'b1, 1'b1, 1'b0); // R4: digit diff -10
        chk("R4 digit -10 corrected", {8'h00, res_out[7:0]}, 16'h0090);
        apply(16'h9999, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b1); // R2/R3: full ripple
        chk("R2 ripple to 0000", res_out, 16'h0000);
        chk("R3 carry out of top digit", {15'b0, carry_out}, 16'h0001);
        keep_r = res_out;
        keep_c = carry_out;

        // R1: inputs change without in_valid, outputs hold
        @(negedge clk);
        acc_in = 16'h5555; opnd_in = 16'h2222; carry_in = 1'b1; dec_in = 1'b0;
        sub_in = 1'b1; wide_in = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        chk("R1 hold result", res_out, keep_r);
        chk("R1 hold carry", {15'b0, carry_out}, {15'b0, keep_c});
        chk("R1 out_valid low when idle", {15'b0, out_valid}, 16'h0000);

        // narrow sweep: every accumulator byte against digit-boundary operands
        for (int a = 0; a < 256; a++) begin
            for (int k = 0; k < 16; k++) begin
                for (int m = 0; m < 8; m++) begin
                    logic [7:0] ab;
                    logic [7:0] bb;
                    ab = 8'(a);
                    bb = opnd_pick(k);
                    apply({ab ^ 8'h5A, ab}, {~ab, bb}, m[0], m[1], m[2], 1'b0);
                end
            end
        end

        // wide vectors, half of them made of legal digits
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] av;
            logic [15:0] bv;
            seed = next_rand(seed);
            av = seed[15:0];
            bv = seed[31:16];
            if (i[0]) begin
                for (int d = 0; d < 4; d++) begin
                    av[d*4 +: 4] = 4'(int'(av[d*4 +: 4]) % 10);
                    bv[d*4 +: 4] = 4'(int'(bv[d*4 +: 4]) % 10);
                end
            end
            seed = next_rand(seed);
            apply(av, bv, seed[0], seed[1], seed[2], 1'b1);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule